// File: doc/BRIEF.md
# Streaming Linear Regression Predictor

This block learns a straight-line model from a stream of 8-bit sample pairs (x, y) and, on request, uses that model to estimate y for a query x. For every accepted pair it updates five running totals: the sample count, Σx, Σy, Σxy and Σx². A single signed multiplier is shared in time. It forms the two products a new sample needs during the three cycles after the sample is taken. It also forms the eight products a prediction needs, and it is driven with zero in every other cycle.

A prediction is worked out exactly as one fraction, ŷ = (Σy·D + S·(n·xq − Σx)) / (n·D), where S = nΣxy − ΣxΣy and D = nΣx² − (Σx)². This fraction is then rounded half-up by an 8-step restoring divider and clamped to 0..255. The intake rate is one pair every four clock edges. A prediction request may arrive in any cycle. It is held until the block is idle and is then serviced.

Top module: `linreg_predictor`

## Requirements
- R1: A clock edge with `rst_n` low (synchronous reset) empties the model. Afterwards `ready` is 1, `pred_done` is 0, `pred_y` is 0, and a later prediction made without new samples returns 0.
- R2: A pair is taken at an edge where `ready` and `smp_valid` are both 1. `ready` is then 0 for the next three cycles, so at most one pair is taken per four edges.
- R3: A pair presented while `ready` is 0 has no effect on the model.
- R4: Each accepted pair adds 1 to the count and adds x, y, x·y and x² to the four sums. Data lying on an exact integer line gives that line's value back.
- R5: The count saturates at 2^CNT_W − 1. Pairs accepted after that point leave the model unchanged.
- R6: A `pred_req` pulse is latched together with `pred_x` when no request is pending or in service. Otherwise it is ignored. A latched request makes `ready` 0 and is started at the first edge at which the block is idle.
- R7: Servicing starts one edge after the latch when the block was idle. `pred_done` is then high for exactly one cycle, in the cycle after the 18th edge following the latch edge. `pred_y` holds its value until the next result.
- R8: The result is the least-squares estimate rounded to nearest, with an exact half rounded up.
- R9: With zero samples the result is 0.
- R10: When nΣx² − (Σx)² is 0 (a single sample, or all x equal), the result is the mean of y, rounded half up.
- R11: Estimates below 0 give 0 and estimates above 255 give 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears the model |
| smp_valid | input | 1 | Sample pair offered this cycle |
| smp_x | input | 8 | Sample independent value |
| smp_y | input | 8 | Sample dependent value |
| ready | output | 1 | A pair offered now is taken at the next edge |
| pred_req | input | 1 | Prediction request strobe |
| pred_x | input | 8 | Query x, latched with the request |
| pred_y | output | 8 | Rounded, clamped prediction |
| pred_done | output | 1 | One-cycle pulse: `pred_y` is new |

## Verification
The hardest situation to reach is a request that arrives while a sample update is still running and is then overlapped by a second request during service. The stimulus reaches it by raising `pred_req` in the cycle right after a pair is taken. It then pulses a different query a few cycles later, and checks that only the first query is answered and that only one done pulse appears. Count saturation would need 65535 samples at the default width, so the bench instantiates the block with a 5-bit count. It then feeds pairs past the limit that would visibly move the line.

// File: rtl/linreg_pkg.sv
// Package: shared state encoding for the linear regression predictor.
// Assumes: no other block decodes these values.
package linreg_pkg;

    // Controller phases: idle, three sample-update steps, product steps,
    // divider setup, division, result strobe.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_UPD1 = 3'd1,
        ST_UPD2 = 3'd2,
        ST_UPD3 = 3'd3,
        ST_PRED = 3'd4,
        ST_PREP = 3'd5,
        ST_DIV  = 3'd6,
        ST_FIN  = 3'd7
    } lr_state_e;

endpackage

// File: rtl/linreg_mul.sv
// Module: linreg_mul
// Shared signed multiplier, purely combinational. Both operands are
// sign-extended to the product width before the multiply.
// Assumes: the product of any operand pair the controller selects fits P_W.
module linreg_mul #(
    parameter int A_W = 50,
    parameter int B_W = 26,
    parameter int P_W = A_W + B_W
) (
    input  logic signed [A_W-1:0] op_a,
    input  logic signed [B_W-1:0] op_b,
    output logic signed [P_W-1:0] prod
);

    // Full-width signed product.
    always_comb begin
        prod = P_W'(op_a) * P_W'(op_b);
    end

endmodule

// File: rtl/linreg_accum.sv
// Module: linreg_accum
// Holds the sample count and the four running sums. n, Σx and Σy are
// updated at the capture edge. Σxy and Σx² are added from the shared
// multiplier in the two steps that follow.
// Assumes: add_xy and add_xx come one and two cycles after cap, never
// together with it.
module linreg_accum #(
    parameter int DW    = 8,
    parameter int CNT_W = 16,
    parameter int SX_W  = CNT_W + DW,
    parameter int SXY_W = CNT_W + 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [DW-1:0]    x_in,
    input  logic [DW-1:0]    y_in,
    input  logic             add_xy,
    input  logic             add_xx,
    input  logic [SXY_W-1:0] prod_lo,
    output logic [CNT_W-1:0] n_o,
    output logic [SX_W-1:0]  sx_o,
    output logic [SX_W-1:0]  sy_o,
    output logic [SXY_W-1:0] sxy_o,
    output logic [SXY_W-1:0] sxx_o,
    output logic [DW-1:0]    xs_o,
    output logic [DW-1:0]    ys_o
);

    localparam logic [CNT_W-1:0] N_MAX = '1;

    logic [CNT_W-1:0] n_q;
    logic [SX_W-1:0]  sx_q, sy_q;
    logic [SXY_W-1:0] sxy_q, sxx_q;
    logic [DW-1:0]    xs_q, ys_q;
    logic             keep_q;   // this sample counts (count not full)

    // Capture the pair and update the first-order sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= '0;
            sx_q   <= '0;
            sy_q   <= '0;
            xs_q   <= '0;
            ys_q   <= '0;
            keep_q <= 1'b0;
        end else if (cap) begin
            xs_q   <= x_in;
            ys_q   <= y_in;
            keep_q <= (n_q != N_MAX);
            if (n_q != N_MAX) begin
                n_q  <= n_q + CNT_W'(1);
                sx_q <= sx_q + SX_W'(x_in);
                sy_q <= sy_q + SX_W'(y_in);
            end
        end
    end

    // Add the shared-multiplier products to the second-order sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sxy_q <= '0;
            sxx_q <= '0;
        end else begin
            if (add_xy && keep_q) sxy_q <= sxy_q + prod_lo;
            if (add_xx && keep_q) sxx_q <= sxx_q + prod_lo;
        end
    end

    assign n_o   = n_q;
    assign sx_o  = sx_q;
    assign sy_o  = sy_q;
    assign sxy_o = sxy_q;
    assign sxx_o = sxx_q;
    assign xs_o  = xs_q;
    assign ys_o  = ys_q;

    // R5
    sat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && n_q == N_MAX) |=> ($stable(n_q) && $stable(sx_q) && $stable(sy_q)));

    // R4
    count_only_on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(n_q));

endmodule

// File: rtl/linreg_div.sv
// Module: linreg_div
// Restoring divider for the QW quotient bits, MSB first, one bit per
// step. The caller has already checked that num < den << QW, or else it
// sets force_hi. res_nx is the result as it will be after the step
// taken now, so the caller can register it at the last step.
// Assumes: load and step are never high together.
module linreg_div #(
    parameter int DV_W = 80,
    parameter int QW   = 8,
    parameter int CW   = (QW > 1) ? $clog2(QW) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [DV_W-1:0] num_in,
    input  logic [DV_W-1:0] den_in,
    input  logic            force_lo,
    input  logic            force_hi,
    output logic [QW-1:0]   res_nx,
    output logic            last
);

    logic [DV_W-1:0] rem_q, den_q, trial;
    logic [QW-1:0]   q_q, q_nx;
    logic [CW-1:0]   cnt_q;
    logic            lo_q, hi_q, fits;

    // Trial subtraction for the current quotient bit.
    always_comb begin
        trial  = den_q << cnt_q;
        fits   = (rem_q >= trial);
        q_nx   = q_q | (fits ? (QW'(1) << cnt_q) : '0);
        res_nx = lo_q ? '0 : (hi_q ? '1 : q_nx);
        last   = (cnt_q == '0);
    end

    // Load operands, then retire one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            q_q   <= '0;
            cnt_q <= '0;
            lo_q  <= 1'b0;
            hi_q  <= 1'b0;
        end else if (load) begin
            rem_q <= num_in;
            den_q <= den_in;
            q_q   <= '0;
            cnt_q <= CW'(QW - 1);
            lo_q  <= force_lo;
            hi_q  <= force_hi;
        end else if (step) begin
            if (fits) rem_q <= rem_q - trial;
            q_q   <= q_nx;
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // R8
    rem_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q <= $past(rem_q)));

endmodule

// File: rtl/linreg_predictor.sv
// Module: linreg_predictor (top)
// Paces sample intake to one pair per four edges, keeps the regression
// sums, and services prediction requests with one shared multiplier
// (8 product steps) and a restoring divider (1 setup + QW steps).
// Assumes: the query x is latched with the request; the sums cannot
// change during service because no sample is taken then.
module linreg_predictor #(
    parameter int DW    = 8,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_x,
    input  logic [DW-1:0] smp_y,
    output logic          ready,
    input  logic          pred_req,
    input  logic [DW-1:0] pred_x,
    output logic [DW-1:0] pred_y,
    output logic          pred_done
);
    import linreg_pkg::*;

    localparam int SX_W  = CNT_W + DW;
    localparam int SXY_W = CNT_W + 2 * DW;
    localparam int PW    = 2 * CNT_W + 2 * DW;
    localparam int A_W   = PW + 2;
    localparam int B_W   = SX_W + 2;
    localparam int M_W   = A_W + B_W;

    lr_state_e state;
    logic [2:0] k_q;
    logic       pend_q, cap, busy_pred;
    logic [DW-1:0] qx_q, pred_y_q;

    logic [CNT_W-1:0] n;
    logic [SX_W-1:0]  sx, sy;
    logic [SXY_W-1:0] sxy, sxx;
    logic [DW-1:0]    xs, ys;

    logic signed [A_W-1:0] op_a, num_r, den_r;
    logic signed [B_W-1:0] op_b, t_r;
    logic signed [M_W-1:0] prod, tmp_r, nn_r, dd_r;

    logic [M_W-1:0] n_sel, d_sel, num2, d2;
    logic           deg, f_lo, f_hi, div_last;
    logic [DW-1:0]  div_res;

    assign ready     = (state == ST_IDLE) && !pend_q;
    assign cap       = ready && smp_valid;
    assign busy_pred = (state == ST_PRED) || (state == ST_PREP) ||
                       (state == ST_DIV)  || (state == ST_FIN);
    assign pred_done = (state == ST_FIN);
    assign pred_y    = pred_y_q;

    linreg_accum #(.DW(DW), .CNT_W(CNT_W), .SX_W(SX_W), .SXY_W(SXY_W)) accum_i (
        .clk(clk), .rst_n(rst_n), .cap(cap), .x_in(smp_x), .y_in(smp_y),
        .add_xy(state == ST_UPD1), .add_xx(state == ST_UPD2),
        .prod_lo(prod[SXY_W-1:0]),
        .n_o(n), .sx_o(sx), .sy_o(sy), .sxy_o(sxy), .sxx_o(sxx),
        .xs_o(xs), .ys_o(ys)
    );

    linreg_mul #(.A_W(A_W), .B_W(B_W), .P_W(M_W)) mul_i (
        .op_a(op_a), .op_b(op_b), .prod(prod)
    );

    // Operand select for the shared multiplier; zero when unused.
    always_comb begin
        op_a = '0;
        op_b = '0;
        case (state)
            ST_UPD1: begin op_a = A_W'(xs); op_b = B_W'(ys); end
            ST_UPD2: begin op_a = A_W'(xs); op_b = B_W'(xs); end
            ST_PRED: begin
                case (k_q)
                    3'd0: begin op_a = A_W'(sxy); op_b = B_W'(n);    end
                    3'd1: begin op_a = A_W'(sy);  op_b = B_W'(sx);   end
                    3'd2: begin op_a = A_W'(sxx); op_b = B_W'(n);    end
                    3'd3: begin op_a = A_W'(sx);  op_b = B_W'(sx);   end
                    3'd4: begin op_a = A_W'(n);   op_b = B_W'(qx_q); end
                    3'd5: begin op_a = den_r;     op_b = B_W'(sy);   end
                    3'd6: begin op_a = num_r;     op_b = t_r;        end
                    default: begin op_a = den_r;  op_b = B_W'(n);    end
                endcase
            end
            default: ;
        endcase
    end

    // Divider setup: choose the fraction, flag empty/negative/overflow.
    always_comb begin
        deg   = (den_r == '0);
        n_sel = deg ? M_W'(sy) : nn_r;
        d_sel = deg ? M_W'(n)  : dd_r;
        num2  = (n_sel << 1) + d_sel;
        d2    = d_sel << 1;
        f_lo  = (n == '0) || (!deg && nn_r[M_W-1]);
        f_hi  = (num2 >= (d2 << DW));
    end

    linreg_div #(.DV_W(M_W), .QW(DW)) div_i (
        .clk(clk), .rst_n(rst_n), .load(state == ST_PREP), .step(state == ST_DIV),
        .num_in(num2), .den_in(d2), .force_lo(f_lo), .force_hi(f_hi),
        .res_nx(div_res), .last(div_last)
    );

    // Product-step registers: slope parts, offset term, final fraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_r <= '0; num_r <= '0; den_r <= '0;
            t_r   <= '0; nn_r  <= '0; dd_r  <= '0;
        end else if (state == ST_PRED) begin
            case (k_q)
                3'd0:    tmp_r <= prod;
                3'd1:    num_r <= tmp_r[A_W-1:0] - prod[A_W-1:0];
                3'd2:    tmp_r <= prod;
                3'd3:    den_r <= tmp_r[A_W-1:0] - prod[A_W-1:0];
                3'd4:    t_r   <= prod[B_W-1:0] - B_W'(sx);
                3'd5:    tmp_r <= prod;
                3'd6:    nn_r  <= tmp_r + prod;
                default: dd_r  <= prod;
            endcase
        end
    end

    // Phase sequencing, request latching and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            k_q      <= '0;
            pend_q   <= 1'b0;
            qx_q     <= '0;
            pred_y_q <= '0;
        end else begin
            if (pred_req && !pend_q && !busy_pred) begin
                pend_q <= 1'b1;
                qx_q   <= pred_x;
            end
            case (state)
                ST_IDLE: begin
                    if (pend_q) begin
                        state  <= ST_PRED;
                        k_q    <= '0;
                        pend_q <= 1'b0;
                    end else if (cap) begin
                        state <= ST_UPD1;
                    end
                end
                ST_UPD1: state <= ST_UPD2;
                ST_UPD2: state <= ST_UPD3;
                ST_UPD3: state <= ST_IDLE;
                ST_PRED: begin
                    k_q <= k_q + 3'd1;
                    if (k_q == 3'd7) state <= ST_PREP;
                end
                ST_PREP: state <= ST_DIV;
                ST_DIV: begin
                    if (div_last) begin
                        state    <= ST_FIN;
                        pred_y_q <= div_res;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    intake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && smp_valid) |=> (!ready ##1 !ready ##1 !ready));

    // R3
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ready) |=> ($stable(sx) && $stable(sy)));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_req && busy_pred) |=> $stable(qx_q));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_done |=> !pred_done);

    // R9
    empty_model_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_done && n == '0) |-> (pred_y == '0));

endmodule

// File: tb/linreg_predictor_tb.sv
`timescale 1ns/1ps
module linreg_predictor_tb_top;

    localparam int CW   = 5;
    localparam int NMAX = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_x = '0, smp_y = '0;
    logic       ready;
    logic       pred_req = 1'b0;
    logic [7:0] pred_x = '0;
    logic [7:0] pred_y;
    logic       pred_done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    linreg_predictor #(.DW(8), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_x(smp_x),
        .smp_y(smp_y), .ready(ready), .pred_req(pred_req), .pred_x(pred_x),
        .pred_y(pred_y), .pred_done(pred_done)
    );

    always #10 clk = ~clk;

    // Reference state
    longint m_n, m_sx, m_sy, m_sxy, m_sxx;
    int     upd_left, pred_left, m_qx, m_res, m_out;
    bit     m_pend;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_pred(longint n, longint sx, longint sy,
                                    longint sxy, longint sxx, longint q);
        longint den, num, nn, dd, r;
        if (n == 0) return 0;
        den = n * sxx - sx * sx;
        if (den == 0) begin
            nn = sy; dd = n;
        end else begin
            num = n * sxy - sx * sy;
            nn  = sy * den + num * (n * q - sx);
            dd  = n * den;
        end
        if (nn < 0) return 0;
        r = (2 * nn + dd) / (2 * dd);
        return (r > 255) ? 255 : int'(r);
    endfunction

    // Cycle model of pacing, request handling and result timing.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_sx = 0; m_sy = 0; m_sxy = 0; m_sxx = 0;
            upd_left = 0; pred_left = 0; m_pend = 0; m_qx = 0; m_res = 0; m_out = 0;
        end else begin
            bit idle, capt, startp, latch;
            idle   = (upd_left == 0) && (pred_left == 0);
            capt   = idle && !m_pend && smp_valid;
            startp = idle && m_pend;
            latch  = pred_req && !m_pend && (pred_left == 0);
            if (upd_left > 0) upd_left--;
            if (pred_left > 0) begin
                pred_left--;
                if (pred_left == 1) m_out = m_res;
            end
            if (capt) begin
                upd_left = 3;
                if (m_n < NMAX) begin
                    m_n++; m_sx += smp_x; m_sy += smp_y;
                    m_sxy += smp_x * smp_y; m_sxx += smp_x * smp_x;
                end
            end
            if (startp) begin
                pred_left = 18;
                m_pend = 0;
                m_res = ref_pred(m_n, m_sx, m_sy, m_sxy, m_sxx, m_qx);
            end
            if (latch) begin
                m_pend = 1;
                m_qx = pred_x;
            end
        end
    end

    // Compare against the model every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit er;
            er = (upd_left == 0) && (pred_left == 0) && !m_pend;
            chk(ready == er, "R2 ready", ready, er);
            chk(pred_done == (pred_left == 1), "R7 done", pred_done, pred_left == 1);
            chk(pred_y == m_out, "R8 pred_y", pred_y, m_out);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input int x, input int y);
        @(negedge clk);
        while (!ready) @(negedge clk);
        smp_valid = 1'b1; smp_x = 8'(x); smp_y = 8'(y);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_pred(input int x, input int exp, input string tag);
        int  cnt;
        bit  was_idle;
        @(negedge clk);
        was_idle = ready;
        pred_req = 1'b1; pred_x = 8'(x);
        cnt = 0;
        do begin
            @(negedge clk);
            pred_req = 1'b0;
            cnt++;
        end while (!pred_done && cnt < 80);
        if (was_idle) chk(cnt == 19, "R7 latency", cnt, 19);
        chk(pred_y == 8'(exp), tag, pred_y, exp);
    endtask

    initial begin
        int dones;
        do_reset();
        // R1 reset state
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(pred_done == 1'b0, "R1 done", pred_done, 0);
        chk(pred_y == 8'd0, "R1 pred_y", pred_y, 0);
        // R9 empty model
        do_pred(5, 0, "R9 empty");
        // R10 single sample and equal x
        send(10, 40);
        do_pred(99, 40, "R10 single");
        send(10, 41);
        send(10, 44);
        do_pred(3, 42, "R10 mean");
        // R1 reset clears model
        do_reset();
        do_pred(17, 0, "R1 cleared");
        // R4 exact line y = 2x + 3
        send(0, 3); send(10, 23); send(20, 43); send(30, 63);
        do_pred(50, 103, "R4 line");
        do_pred(7, 17, "R4 line low");
        // R8 half rounding, slope 0.5
        do_reset();
        send(0, 0); send(2, 1);
        do_pred(1, 1, "R8 half");
        do_pred(3, 2, "R8 one-and-half");
        // R11 clamp high and low
        do_reset();
        send(0, 0); send(10, 100);
        do_pred(100, 255, "R11 high");
        do_reset();
        send(0, 200); send(10, 100);
        do_pred(50, 0, "R11 low");
        // R3 valid held high: only i = 0, 4, 8 are taken (y = 2x)
        do_reset();
        for (int i = 0; i < 12; i++) begin
            smp_valid = 1'b1; smp_x = 8'(i);
            smp_y = (i % 4 == 0) ? 8'(2 * i) : 8'd250;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        do_pred(20, 40, "R3 ignored");
        // R6 request during update, second request during service ignored
        do_reset();
        send(0, 5);
        send(2, 9);
        pred_req = 1'b1; pred_x = 8'd4;
        @(negedge clk);
        pred_req = 1'b0;
        repeat (5) @(negedge clk);
        pred_req = 1'b1; pred_x = 8'd100;
        @(negedge clk);
        pred_req = 1'b0;
        dones = 0;
        for (int i = 0; i < 60; i++) begin
            if (pred_done) begin
                dones++;
                chk(pred_y == 8'd13, "R6 pending", pred_y, 13);
            end
            @(negedge clk);
        end
        chk(dones == 1, "R6 one answer", dones, 1);
        // R5 count saturation at 31 samples; later pairs off the line
        do_reset();
        send(0, 0);
        for (int i = 0; i < 30; i++) send(10, 10);
        for (int i = 0; i < 4; i++) send(255, 0);
        do_pred(200, 200, "R5 saturate");
        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule